// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This block computes the effective memory address of a load from a mode code, two register selectors and a 16-bit signed offset. It owns an eight-entry general-purpose register file. For six of the seven legal modes the address comes from register contents, the offset, or both. One mode needs a pointer that lives in memory: the unit raises a request/valid read to fetch that word, and the returned word becomes the address. The two post-modify modes also write an updated base register back into the file.

Each operation starts with a one-cycle `start_i` pulse while the unit is idle. The result appears on `ea_o` together with a one-cycle `done_o` pulse. A side write port loads the register file while the unit is idle. The register-indirect mode reads any register back through `ea_o`.

Top module: `ea_unit`

## Requirements
- R1: After reset `done_o`, `mem_req_o`, `busy_o` and `illegal_o` are low, `ea_o` is zero and every register holds zero.
- R2: Mode code 0 (absolute) yields the offset sign-extended from 16 to 32 bits.
- R3: Mode code 1 yields the base register contents. Mode code 2 yields the base register plus the sign-extended offset, wrapping modulo 2^32.
- R4: Mode code 3 yields the base register plus the index register, wrapping modulo 2^32.
- R5: Mode code 4 sets `mem_req_o` in the cycle after start, with `mem_addr_o` equal to the base register. Both stay unchanged until `mem_rvalid_i`. In the cycle after `mem_rvalid_i`, `done_o` is high, `ea_o` equals the returned `mem_rdata_i` and `mem_req_o` is low.
- R6: Mode code 5 yields the old base value and then adds the step to the base register. The step is 1 for `step_i`=0, 2 for `step_i`=1, and 4 for `step_i`=2 or 3.
- R7: Mode code 6 yields the old base value and then subtracts the same step from the base register, wrapping modulo 2^32.
- R8: Register 0 always reads as zero. Writes to it from the side port or from post-modify writeback have no effect.
- R9: Mode code 7 is reserved. It gives `done_o` with `illegal_o` high and `ea_o` zero, and it changes no register. `illegal_o` falls at the next completed operation with a legal mode.
- R10: For every mode except 4, `done_o` is high for exactly the one cycle after the accepted start, unless another start is accepted in that cycle.
- R11: A start while `busy_o` is high is ignored. It produces no extra completion and no register writeback.
- R12: The side write port updates a register only when the unit is idle and `start_i` is low. Otherwise the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an address computation |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 3 | Base register selector |
| idx_sel_i | input | 3 | Index register selector |
| ofs_i | input | 16 | Signed offset / immediate |
| step_i | input | 2 | Post-modify access size code |
| rf_we_i | input | 1 | Side register write enable |
| rf_waddr_i | input | 3 | Side register write selector |
| rf_wdata_i | input | 32 | Side register write data |
| mem_req_o | output | 1 | Pointer read request |
| mem_addr_o | output | 32 | Pointer read address |
| mem_rvalid_i | input | 1 | Pointer read data valid |
| mem_rdata_i | input | 32 | Pointer read data |
| busy_o | output | 1 | Pointer fetch in progress |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 32 | Effective address |
| illegal_o | output | 1 | Reserved mode used |

## Verification
The hardest case to reach is a start, or a side-port write, that arrives while a pointer fetch is still waiting for memory. It only occurs when the memory response is held back. The bench issues a memory-indirect operation and keeps `mem_rvalid_i` low for several cycles. While the fetch waits, it pulses a post-modify start and a side write aimed at registers it can read afterwards. It then releases the response and reads those registers back through register-indirect operations, which shows that neither the start nor the write took effect.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_ABS  = 3'd0,
    M_RIND = 3'd1,
    M_DISP = 3'd2,
    M_INDX = 3'd3,
    M_MIND = 3'd4,
    M_AINC = 3'd5,
    M_ADEC = 3'd6,
    M_RSVD = 3'd7
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ea_state_e;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [SEL_W-1:0] raddr_a_i,
  output logic [XLEN-1:0]  rdata_a_o,
  input  logic [SEL_W-1:0] raddr_b_i,
  output logic [XLEN-1:0]  rdata_b_o
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                regs[g] <= '0;
        else if (we_i && waddr_i == SEL_W'(g))      regs[g] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16
) (
  input  logic [2:0]       mode_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  idx_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       step_i,
  output logic [XLEN-1:0]  ea_o,
  output logic [XLEN-1:0]  new_base_o,
  output logic             wb_o,
  output logic             fetch_o,
  output logic             illegal_o
);
  logic [XLEN-1:0] ofs_ext;
  logic [XLEN-1:0] step_val;
  ea_mode_e        mode;

  assign mode    = ea_mode_e'(mode_i);
  assign ofs_ext = {{(XLEN-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

  always_comb begin
    unique case (step_i)
      2'd0:    step_val = XLEN'(1);
      2'd1:    step_val = XLEN'(2);
      default: step_val = XLEN'(4);
    endcase
  end

  always_comb begin
    ea_o       = '0;
    new_base_o = base_i;
    wb_o       = 1'b0;
    fetch_o    = 1'b0;
    illegal_o  = 1'b0;
    unique case (mode)
      M_ABS:  ea_o = ofs_ext;
      M_RIND: ea_o = base_i;
      M_DISP: ea_o = base_i + ofs_ext;
      M_INDX: ea_o = base_i + idx_i;
      M_MIND: fetch_o = 1'b1;
      M_AINC: begin
        ea_o       = base_i;
        new_base_o = base_i + step_val;
        wb_o       = 1'b1;
      end
      M_ADEC: begin
        ea_o       = base_i;
        new_base_o = base_i - step_val;
        wb_o       = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            fetch_i,
  input  logic            illegal_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            mem_rvalid_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            done_o,
  output logic [XLEN-1:0] ea_o,
  output logic            illegal_o
);
  ea_state_e state_q;

  assign busy_o    = (state_q == ST_FETCH);
  assign mem_req_o = busy_o;
  assign accept_o  = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mem_addr_o <= '0;
      done_o     <= 1'b0;
      ea_o       <= '0;
      illegal_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          if (fetch_i) begin
            state_q    <= ST_FETCH;
            mem_addr_o <= base_i;
          end else begin
            done_o    <= 1'b1;
            ea_o      <= ea_i;
            illegal_o <= illegal_i;
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          state_q   <= ST_IDLE;
          done_o    <= 1'b1;
          ea_o      <= mem_rdata_i;
          illegal_o <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 8,
  parameter int OFS_W = 16,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       mode_i,
  input  logic [SEL_W-1:0] base_sel_i,
  input  logic [SEL_W-1:0] idx_sel_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       step_i,
  input  logic             rf_we_i,
  input  logic [SEL_W-1:0] rf_waddr_i,
  input  logic [XLEN-1:0]  rf_wdata_i,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [XLEN-1:0]  ea_o,
  output logic             illegal_o
);
  logic [XLEN-1:0]  base_val, idx_val, calc_ea, new_base;
  logic             calc_wb, calc_fetch, calc_illegal, accept;
  logic             rf_we;
  logic [SEL_W-1:0] rf_waddr;
  logic [XLEN-1:0]  rf_wdata;

  // writeback wins; side port only when idle with no start
  always_comb begin
    if (accept && calc_wb) begin
      rf_we    = 1'b1;
      rf_waddr = base_sel_i;
      rf_wdata = new_base;
    end else begin
      rf_we    = rf_we_i && !busy_o && !start_i;
      rf_waddr = rf_waddr_i;
      rf_wdata = rf_wdata_i;
    end
  end

  ea_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (base_sel_i),
    .rdata_a_o (base_val),
    .raddr_b_i (idx_sel_i),
    .rdata_b_o (idx_val)
  );

  ea_calc #(.XLEN(XLEN), .OFS_W(OFS_W)) u_calc (
    .mode_i     (mode_i),
    .base_i     (base_val),
    .idx_i      (idx_val),
    .ofs_i      (ofs_i),
    .step_i     (step_i),
    .ea_o       (calc_ea),
    .new_base_o (new_base),
    .wb_o       (calc_wb),
    .fetch_o    (calc_fetch),
    .illegal_o  (calc_illegal)
  );

  ea_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .fetch_i      (calc_fetch),
    .illegal_i    (calc_illegal),
    .ea_i         (calc_ea),
    .base_i       (base_val),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (done_o),
    .ea_o         (ea_o),
    .illegal_o    (illegal_o)
  );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       mode_i,
  input logic [OFS_W-1:0] ofs_i,
  input logic             mem_req_o,
  input logic [XLEN-1:0]  mem_addr_o,
  input logic             mem_rvalid_i,
  input logic [XLEN-1:0]  mem_rdata_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [XLEN-1:0]  ea_o,
  input logic             illegal_o
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_fetch_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_rvalid_i) |=> (done_o && !mem_req_o && ea_o == $past(mem_rdata_i)));

  p_fetch_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 3'd4) |=> (mem_req_o && !done_o));

  p_abs_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 3'd0)
      |=> (ea_o == {{(XLEN-OFS_W){$past(ofs_i[OFS_W-1])}}, $past(ofs_i)}));

  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 3'd7) |=> (done_o && illegal_o && ea_o == '0));

  p_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i != 3'd4) |=> (done_o && !mem_req_o));

  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_rvalid_i) |=> (!done_o && busy_o));
endmodule

bind ea_unit ea_unit_chk #(.XLEN(XLEN), .OFS_W(OFS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .ofs_i        (ofs_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ea_o         (ea_o),
  .illegal_o    (illegal_o)
);

// File: tb/ea_unit_tb_top.sv
`timescale 1ns/1ps
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [2:0]  bsel = '0, xsel = '0;
  logic [15:0] ofs = '0;
  logic [1:0]  step = '0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic        rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic        req, busy, done, illegal;
  logic [31:0] maddr, ea;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ea_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .base_sel_i(bsel), .idx_sel_i(xsel), .ofs_i(ofs), .step_i(step),
    .rf_we_i(we), .rf_waddr_i(waddr), .rf_wdata_i(wdata),
    .mem_req_o(req), .mem_addr_o(maddr), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .ea_o(ea),
    .illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  // returns at the negedge after the start edge
  task automatic issue(input logic [2:0] m, input logic [2:0] b, input logic [2:0] x,
                       input logic [15:0] o, input logic [1:0] s);
    @(negedge clk);
    start = 1'b1; mode = m; bsel = b; xsel = x; ofs = o; step = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic op_chk(input string tag, input logic [2:0] m, input logic [2:0] b,
                        input logic [2:0] x, input logic [15:0] o, input logic [1:0] s,
                        input logic [31:0] exp);
    issue(m, b, x, o, s);
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " ea"}, ea, exp);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] r, input logic [31:0] exp);
    op_chk(tag, 3'd1, r, 3'd0, 16'h0, 2'd0, exp);
  endtask

  task automatic t_reset;
    chk("R1 done", 32'(done), 0);
    chk("R1 req", 32'(req), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 illegal", 32'(illegal), 0);
    chk("R1 ea", ea, 0);
    rd_chk("R1 r4", 3'd4, 32'h0);
  endtask

  task automatic t_load;
    wr_reg(3'd1, 32'h0000_1000);
    wr_reg(3'd2, 32'h0000_0024);
    wr_reg(3'd3, 32'hFFFF_FFF0);
    wr_reg(3'd5, 32'h0000_0000);
    rd_chk("R12 r1", 3'd1, 32'h0000_1000);
    rd_chk("R3 r3", 3'd3, 32'hFFFF_FFF0);
  endtask

  task automatic t_abs;
    op_chk("R2 neg", 3'd0, 3'd1, 3'd0, 16'h8004, 2'd0, 32'hFFFF_8004);
    op_chk("R2 pos", 3'd0, 3'd1, 3'd0, 16'h1234, 2'd0, 32'h0000_1234);
  endtask

  task automatic t_disp_idx;
    op_chk("R3 disp neg", 3'd2, 3'd1, 3'd0, 16'hFFF8, 2'd0, 32'h0000_0FF8);
    op_chk("R3 disp wrap", 3'd2, 3'd3, 3'd0, 16'h0020, 2'd0, 32'h0000_0010);
    op_chk("R4 idx", 3'd3, 3'd1, 3'd2, 16'h7777, 2'd0, 32'h0000_1024);
    op_chk("R4 idx wrap", 3'd3, 3'd3, 3'd2, 16'h0, 2'd0, 32'h0000_0014);
  endtask

  task automatic t_pulse;
    op_chk("R10 op", 3'd1, 3'd2, 3'd0, 16'h0, 2'd0, 32'h24);
    @(negedge clk);
    chk("R10 done low", 32'(done), 0);
  endtask

  task automatic t_autoinc;
    op_chk("R6 step4", 3'd5, 3'd1, 3'd0, 16'h0, 2'd2, 32'h0000_1000);
    rd_chk("R6 r1 +4", 3'd1, 32'h0000_1004);
    op_chk("R6 step1", 3'd5, 3'd1, 3'd0, 16'h0, 2'd0, 32'h0000_1004);
    op_chk("R6 step2", 3'd5, 3'd1, 3'd0, 16'h0, 2'd1, 32'h0000_1005);
    op_chk("R6 step4b", 3'd5, 3'd1, 3'd0, 16'h0, 2'd3, 32'h0000_1007);
    rd_chk("R6 r1 final", 3'd1, 32'h0000_100B);
  endtask

  task automatic t_autodec;
    op_chk("R7 dec", 3'd6, 3'd5, 3'd0, 16'h0, 2'd2, 32'h0);
    rd_chk("R7 r5 wrap", 3'd5, 32'hFFFF_FFFC);
    op_chk("R7 dec2", 3'd6, 3'd5, 3'd0, 16'h0, 2'd1, 32'hFFFF_FFFC);
    rd_chk("R7 r5", 3'd5, 32'hFFFF_FFFA);
  endtask

  task automatic t_r0;
    wr_reg(3'd0, 32'h55);
    rd_chk("R8 side write", 3'd0, 32'h0);
    op_chk("R8 inc", 3'd5, 3'd0, 3'd0, 16'h0, 2'd2, 32'h0);
    rd_chk("R8 after inc", 3'd0, 32'h0);
  endtask

  task automatic t_illegal;
    issue(3'd7, 3'd1, 3'd0, 16'h1234, 2'd2);
    chk("R9 done", 32'(done), 1);
    chk("R9 flag", 32'(illegal), 1);
    chk("R9 ea", ea, 0);
    rd_chk("R9 r1 same", 3'd1, 32'h0000_100B);
    chk("R9 flag clear", 32'(illegal), 0);
  endtask

  task automatic t_indirect;
    issue(3'd4, 3'd2, 3'd0, 16'h0, 2'd0);
    chk("R5 req", 32'(req), 1);
    chk("R5 addr", maddr, 32'h24);
    chk("R5 no done", 32'(done), 0);
    issue(3'd5, 3'd1, 3'd0, 16'h0, 2'd2);
    chk("R11 no done", 32'(done), 0);
    chk("R11 busy", 32'(busy), 1);
    wr_reg(3'd6, 32'h99);
    @(negedge clk);
    chk("R5 req held", 32'(req), 1);
    chk("R5 addr held", maddr, 32'h24);
    rvalid = 1'b1; rdata = 32'hCAFE_0000;
    @(negedge clk);
    rvalid = 1'b0; rdata = '0;
    chk("R5 done", 32'(done), 1);
    chk("R5 ea", ea, 32'hCAFE_0000);
    chk("R5 req low", 32'(req), 0);
    rd_chk("R11 r1 same", 3'd1, 32'h0000_100B);
    rd_chk("R12 busy write", 3'd6, 32'h0);
  endtask

  task automatic t_side_with_start;
    @(negedge clk);
    we = 1'b1; waddr = 3'd4; wdata = 32'h77;
    start = 1'b1; mode = 3'd1; bsel = 3'd2;
    @(negedge clk);
    we = 1'b0; start = 1'b0;
    rd_chk("R12 start write", 3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_abs();
    t_disp_idx();
    t_pulse();
    t_autoinc();
    t_autodec();
    t_r0();
    t_illegal();
    t_indirect();
    t_side_with_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule